// File: doc/BRIEF.md
# Register Post-Update Sequencer

This unit takes the 4-bit post-update code of an extended instruction, works out which operand registers change and in which direction, and then applies those changes to a local register file. An instruction can name registers in four operand slots: a source slot (SRC), a second-source slot (SND), a destination slot (DST) and a condition slot (CND). One code can adjust up to three of these registers by one. When the instruction carries an immediate, two of the four code bits become extra immediate bits. The other two bits then choose from a smaller menu of single updates.

Every change happens after the instruction has used its operands. The unit writes the changes one per cycle, in a fixed slot order, and holds `ready` low until the last write is done. A read port returns the contents of any register combinationally. When an instruction is accepted, the unit reports how many updates it will make and gives the two extra immediate bits.

Top module: `postupd_unit`

## Requirements
- R1: After reset every register reads 0 and `ready` is high.
- R2: With `imm_mode`=1, `imm_ext` equals `upd_code[3:2]`, and `upd_code[1:0]` selects the update: 00 none, 01 SND+1, 10 DST+1, 11 CND-1.
- R3: With `imm_mode`=0 and `upd_code[1]`=1, exactly one register is updated. The row `upd_code[3:2]` picks it: 00 SRC, 01 SND, 10 DST, 11 CND. `upd_code[0]`=1 increments and `upd_code[0]`=0 decrements.
- R4: With `imm_mode`=0 and `upd_code[1:0]`=01, the registers are incremented by row: 00 gives SRC, SND and DST; 01 gives SND and SRC; 10 gives DST and SRC; 11 gives DST and SND.
- R5: With `imm_mode`=0 and `upd_code[1:0]`=00, row 00 makes no update, and rows 01, 10 and 11 decrement the same pairs that R4 increments.
- R6: In the cycle where `in_valid` and `ready` are both high, `upd_count` gives the number of updates (0 to 3). In that same cycle `imm_ext` is valid, and it is 0 when `imm_mode`=0.
- R7: For an accepted instruction with n>0 updates, `ready` is low for exactly n cycles, starting in the cycle after acceptance. There is one register write per cycle. With n=0, `ready` stays high.
- R8: Updates are applied in the order SRC, SND, DST, CND. Each one adds or subtracts 1 modulo 2^32. When several slots name the same register, that register changes by the sum of the updates.
- R9: While `ready` is low, `in_valid` is ignored and no register changes beyond the queued updates.
- R10: `rd_data` returns the current contents of register `rd_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| imm_mode | input | 1 | Source operand is an immediate |
| upd_code | input | 4 | Post-update code, row in [3:2], column in [1:0] |
| src_idx | input | 4 | Register named by the SRC slot |
| snd_idx | input | 4 | Register named by the SND slot |
| dst_idx | input | 4 | Register named by the DST slot |
| cnd_idx | input | 4 | Register named by the CND slot |
| ready | output | 1 | Unit can accept an instruction |
| upd_count | output | 2 | Number of updates of the offered instruction |
| imm_ext | output | 2 | Extra immediate bits in immediate mode |
| rd_idx | input | 4 | Read port index |
| rd_data | output | 32 | Read port data |

## Verification
The bench builds the unit with its defaults: 32-bit registers and 16 entries. With only 16 registers, random slot indices often collide, so R8's accumulation on a shared register is exercised as a matter of course. Because the registers start at zero, the first decrements wrap to all ones. Directed runs cover all 16 codes without an immediate and all 4 codes with one. A junk instruction is also offered while the unit is busy, to show that it is ignored.

// File: rtl/postupd_unit.sv
module postupd_unit #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              imm_mode,
  input  logic [3:0]        upd_code,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [IDX_W-1:0]  snd_idx,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [IDX_W-1:0]  cnd_idx,
  output logic              ready,
  output logic [1:0]        upd_count,
  output logic [1:0]        imm_ext,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] rf [NREGS];
  logic [3:0]        pend_q;
  logic              dec_q;
  logic [IDX_W-1:0]  idx_q [4];

  logic [1:0] row, col;
  logic [3:0] new_mask;
  logic       new_dec;
  logic       accept;
  logic [1:0] slot;
  logic [IDX_W-1:0]  cur_idx;
  logic [DATA_W-1:0] step;

  assign row = upd_code[3:2];
  assign col = upd_code[1:0];

  always_comb begin
    new_mask = 4'b0000;
    new_dec  = 1'b0;
    if (imm_mode) begin
      case (col)
        2'b01:   new_mask = 4'b0010;
        2'b10:   new_mask = 4'b0100;
        2'b11:   begin new_mask = 4'b1000; new_dec = 1'b1; end
        default: new_mask = 4'b0000;
      endcase
    end else if (col[1]) begin
      new_mask = 4'b0001 << row;
      new_dec  = ~col[0];
    end else begin
      new_dec = ~col[0];
      case (row)
        2'd0:    new_mask = col[0] ? 4'b0111 : 4'b0000;
        2'd1:    new_mask = 4'b0011;
        2'd2:    new_mask = 4'b0101;
        default: new_mask = 4'b0110;
      endcase
    end
  end

  assign ready     = (pend_q == 4'b0000);
  assign accept    = in_valid && ready;
  assign upd_count = 2'($countones(new_mask));
  assign imm_ext   = imm_mode ? row : 2'b00;
  assign rd_data   = rf[rd_idx];

  always_comb begin
    if (pend_q[0])      slot = 2'd0;
    else if (pend_q[1]) slot = 2'd1;
    else if (pend_q[2]) slot = 2'd2;
    else                slot = 2'd3;
  end

  assign cur_idx = idx_q[slot];
  assign step    = dec_q ? {DATA_W{1'b1}} : DATA_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 4'b0000;
      dec_q  <= 1'b0;
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
      for (int j = 0; j < 4; j++) idx_q[j] <= '0;
    end else if (accept) begin
      pend_q   <= new_mask;
      dec_q    <= new_dec;
      idx_q[0] <= src_idx;
      idx_q[1] <= snd_idx;
      idx_q[2] <= dst_idx;
      idx_q[3] <= cnd_idx;
    end else if (!ready) begin
      rf[cur_idx]  <= rf[cur_idx] + step;
      pend_q[slot] <= 1'b0;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ready && upd_count != 2'd0) |=> !ready); // R7
  AST_ONE_WRITE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ($countones(pend_q) + 1 == $countones($past(pend_q)))); // R7
  AST_IMM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && imm_mode) |-> (upd_count <= 2'd1)); // R2
  AST_CND_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[3] |-> (pend_q[2:0] == 3'b000)); // R3
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !in_valid) |=> ready); // R9

endmodule

// File: tb/postupd_unit_tb_top.sv
module postupd_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, imm_mode = 1'b0;
  logic [3:0] upd_code = '0, src_idx = '0, snd_idx = '0, dst_idx = '0, cnd_idx = '0, rd_idx = '0;
  logic ready;
  logic [1:0] upd_count, imm_ext;
  logic [31:0] rd_data;
  int checks = 0, failures = 0;
  logic [31:0] mirror [16];

  always #5 clk = ~clk;

  postupd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm_mode(imm_mode),
    .upd_code(upd_code), .src_idx(src_idx), .snd_idx(snd_idx), .dst_idx(dst_idx),
    .cnd_idx(cnd_idx), .ready(ready), .upd_count(upd_count), .imm_ext(imm_ext),
    .rd_idx(rd_idx), .rd_data(rd_data));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Slot mask bit0 SRC, bit1 SND, bit2 DST, bit3 CND; d=1 means decrement
  function automatic void model(input bit imm, input logic [3:0] code,
                                output bit [3:0] m, output bit d);
    m = 4'b0000; d = 1'b0;
    if (imm) begin
      case (code[1:0])
        2'b01: m = 4'b0010;
        2'b10: m = 4'b0100;
        2'b11: begin m = 4'b1000; d = 1'b1; end
        default: m = 4'b0000;
      endcase
    end else begin
      case (code)
        4'h0: m = 4'b0000;
        4'h1: m = 4'b0111;
        4'h2: begin m = 4'b0001; d = 1'b1; end
        4'h3: m = 4'b0001;
        4'h4: begin m = 4'b0011; d = 1'b1; end
        4'h5: m = 4'b0011;
        4'h6: begin m = 4'b0010; d = 1'b1; end
        4'h7: m = 4'b0010;
        4'h8: begin m = 4'b0101; d = 1'b1; end
        4'h9: m = 4'b0101;
        4'hA: begin m = 4'b0100; d = 1'b1; end
        4'hB: m = 4'b0100;
        4'hC: begin m = 4'b0110; d = 1'b1; end
        4'hD: m = 4'b0110;
        4'hE: begin m = 4'b1000; d = 1'b1; end
        default: m = 4'b1000;
      endcase
    end
  endfunction

  function automatic string tag_of(input bit imm, input logic [3:0] code);
    if (imm) return "R2";
    if (code[1]) return "R3";
    if (code[0]) return "R4";
    return "R5";
  endfunction

  task automatic check_regs(input string req);
    for (int r = 0; r < 16; r++) begin
      rd_idx = 4'(r);
      #1;
      chk(rd_data === mirror[r], req, $sformatf("reg%0d", r), rd_data, mirror[r]);
    end
  endtask

  task automatic run_instr(input bit imm, input logic [3:0] code,
                           input logic [3:0] s, input logic [3:0] n,
                           input logic [3:0] d, input logic [3:0] c,
                           input bit inject, input string tag);
    bit [3:0] m; bit dec; int cnt;
    logic [3:0] ix [4];
    @(negedge clk);
    chk(ready === 1'b1, "R7", "ready before accept", ready, 1);
    in_valid = 1'b1; imm_mode = imm; upd_code = code;
    src_idx = s; snd_idx = n; dst_idx = d; cnd_idx = c;
    #1;
    model(imm, code, m, dec);
    cnt = $countones(m);
    chk(upd_count === 2'(cnt), "R6", "upd_count", upd_count, cnt);
    chk(imm_ext === (imm ? code[3:2] : 2'b00), imm ? "R2" : "R6", "imm_ext",
        imm_ext, imm ? code[3:2] : 2'b00);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k <= cnt; k++) begin
      if (k == cnt) in_valid = 1'b0;
      chk(ready === (k == cnt), "R7", $sformatf("ready busy step %0d", k), ready, k == cnt);
      if (k < cnt) begin
        if (inject) begin
          in_valid = 1'b1; imm_mode = 1'b0; upd_code = 4'h1;
          src_idx = 4'd15; snd_idx = 4'd15; dst_idx = 4'd15;
        end
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    ix[0] = s; ix[1] = n; ix[2] = d; ix[3] = c;
    for (int q = 0; q < 4; q++)
      if (m[q]) mirror[ix[q]] = dec ? mirror[ix[q]] - 32'd1 : mirror[ix[q]] + 32'd1;
    check_regs(inject ? "R9" : tag);
  endtask

  initial begin
    #2_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < 16; r++) mirror[r] = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    chk(ready === 1'b1, "R1", "ready after reset", ready, 1);
    check_regs("R1");
    rd_idx = 4'd0; #1;
    chk(rd_data === 32'd0, "R10", "read port", rd_data, 0);

    for (int cd = 0; cd < 16; cd++)
      run_instr(1'b0, 4'(cd), 4'd1, 4'd2, 4'd3, 4'd4, 1'b0, tag_of(1'b0, 4'(cd)));
    for (int cd = 0; cd < 16; cd++)
      run_instr(1'b1, 4'(cd), 4'd5, 4'd6, 4'd7, 4'd8, 1'b0, "R2");
    run_instr(1'b0, 4'h1, 4'd9, 4'd9, 4'd9, 4'd0, 1'b0, "R8");
    run_instr(1'b0, 4'h4, 4'd10, 4'd10, 4'd0, 4'd0, 1'b0, "R8");
    run_instr(1'b0, 4'h1, 4'd11, 4'd12, 4'd13, 4'd0, 1'b1, "R9");
    run_instr(1'b0, 4'hE, 4'd0, 4'd0, 4'd0, 4'd14, 1'b0, "R8");

    for (int t = 0; t < 300; t++) begin
      bit imm; logic [3:0] code;
      imm = 1'($urandom);
      code = 4'($urandom);
      run_instr(imm, code, 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
                ($urandom % 8) == 0, "R8");
    end
    summary();
  end
endmodule